// File: doc/BRIEF.md
# Byte-Wide Write-Once Memory with Mode Decode

This block is a clocked, synthesizable model of a byte-wide memory that can only have bits cleared by programming and only be returned to all ones by a bulk erase. Two active-low strobes, a chip select and an output gate, work with two mode flags. One flag stands in for the raised programming supply. The other stands in for the raised identifier level on address bit 9. Together they choose among seven modes: read, output disable, standby, program, program verify, program inhibit and signature. The bidirectional data bus is split into an input byte, an output byte and a drive-enable flag.

A program write follows a strobe pulse. While the chip select is low in program mode, the model samples address and data on every clock edge. On the first edge where the chip select is seen high again, it merges the last sample into the array with a bitwise AND. An erase command, and leaving reset, sweep the array to all ones, one location per cycle. A busy flag stays up during the sweep, and any driven read returns all ones while it runs. Signature mode replaces the array with two fixed identifier bytes. Address bit 0 picks which one. Both bytes are checked at elaboration to have odd parity in bit 7.

Top module: `uvprom_array`

## Requirements
- R1: After reset is released, `busy` stays high while every location is written to 0xFF. From then until the next program, every location reads 0xFF.
- R2: Programming stores the bitwise AND of the byte already held and the byte presented, so bits only ever go from 1 to 0.
- R3: With `vpp_hi`=1 and `oe_n`=1, the array takes the address and data sampled on the last clock edge that saw `ce_n` low. The write commits on the next edge that sees `ce_n` high, provided `vpp_hi` is still 1.
- R4: Read mode (`ce_n`=0, `oe_n`=0, `vpp_hi`=0, `id_hi`=0) sets `dq_oe`=1 and drives the addressed byte on `dout`.
- R5: Standby (`ce_n`=1, `vpp_hi`=0) sets `dq_oe`=0 and `dout`=0 whatever `oe_n` is.
- R6: Output disable (`ce_n`=0, `oe_n`=1, `vpp_hi`=0) sets `dq_oe`=0 and `dout`=0.
- R7: Program inhibit (`vpp_hi`=1, `ce_n`=1, `oe_n`=1) does not drive the bus and leaves the array unchanged.
- R8: Program verify (`vpp_hi`=1, `ce_n`=1, `oe_n`=0) sets `dq_oe`=1 and drives the addressed stored byte.
- R9: In read mode with `id_hi`=1, `dout` is 0x97 when `addr[0]`=0 and 0x04 when `addr[0]`=1, whatever the array holds.
- R10: When `erase`=1 is seen while idle, `busy` rises on the next cycle and every location is set to 0xFF. While `busy`=1, driven reads return 0xFF and program pulses are discarded.
- R11: Only the low log2(DEPTH) address bits select a location. Locations can be programmed in any order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release starts an erase sweep |
| ce_n | input | 1 | Active-low chip select / program strobe |
| oe_n | input | 1 | Active-low output gate |
| vpp_hi | input | 1 | Programming supply raised |
| id_hi | input | 1 | Identifier level present on address bit 9 |
| addr | input | 15 | Byte address |
| din | input | 8 | Data presented for programming |
| erase | input | 1 | Bulk erase command |
| dout | output | 8 | Data driven toward the bus |
| dq_oe | output | 1 | Bus drive enable |
| busy | output | 1 | Erase sweep in progress |

## Verification
A pending-write register that is wrongly set or cleared shows up as a byte altered at the wrong address, or left unaltered. The first verify or read of that location after the strobe rises exposes it, one cycle later. A fault in the sweep counter leaves stray zeros, or a `busy` flag that ends early or never. Reads across the array right after `busy` falls show this. Mode decode faults appear at once on `dq_oe` for the same combination of strobes and flags.

// File: rtl/uvprom_array.sv
module uvprom_array #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int DEPTH = 512,
  parameter logic [DATA_W-1:0] MFG_CODE = 8'h97,
  parameter logic [DATA_W-1:0] DEV_CODE = 8'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_hi,
  input  logic              id_hi,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              erase,
  output logic [DATA_W-1:0] dout,
  output logic              dq_oe,
  output logic              busy
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  if (^MFG_CODE !== 1'b1 || ^DEV_CODE !== 1'b1) begin : g_bad_parity
    $error("identifier bytes must carry odd parity");
  end

  logic [DATA_W-1:0] mem [DEPTH];
  logic              wiping;
  logic [IDX_W-1:0]  wipe_idx;
  logic              pend_v;
  logic [IDX_W-1:0]  pend_a;
  logic [DATA_W-1:0] pend_d;

  wire [IDX_W-1:0] idx = addr[IDX_W-1:0];
  wire prog_low = vpp_hi & ~ce_n & oe_n;
  wire commit   = pend_v & ce_n & vpp_hi & ~wiping;
  wire rd_mode  = ~ce_n & ~oe_n & ~vpp_hi;
  wire vfy_mode = ce_n & ~oe_n & vpp_hi;
  wire [DATA_W-1:0] sig = addr[0] ? DEV_CODE : MFG_CODE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wiping   <= 1'b1;
      wipe_idx <= '0;
    end else if (wiping) begin
      wipe_idx <= wipe_idx + 1'b1;
      if (wipe_idx == LAST) wiping <= 1'b0;
    end else if (erase) begin
      wiping   <= 1'b1;
      wipe_idx <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v <= 1'b0;
      pend_a <= '0;
      pend_d <= '0;
    end else if (wiping) begin
      pend_v <= 1'b0;
    end else if (prog_low) begin
      pend_v <= 1'b1;
      pend_a <= idx;
      pend_d <= din;
    end else if (ce_n) begin
      pend_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wiping) mem[wipe_idx] <= '1;
    else if (commit) mem[pend_a] <= mem[pend_a] & pend_d;
  end

  assign dq_oe = rd_mode | vfy_mode;
  assign busy  = wiping;
  assign dout  = !dq_oe ? '0 :
                 wiping ? '1 :
                 (rd_mode & id_hi) ? sig : mem[idx];
endmodule

// File: rtl/uvprom_array_chk.sv
module uvprom_array_chk #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] MFG_CODE = 8'h97,
  parameter logic [DATA_W-1:0] DEV_CODE = 8'h04
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              vpp_hi,
  input logic              id_hi,
  input logic [ADDR_W-1:0] addr,
  input logic              erase,
  input logic [DATA_W-1:0] dout,
  input logic              dq_oe,
  input logic              busy
);
  // R5
  standby_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && !vpp_hi) |-> (!dq_oe && dout == '0));
  // R6
  outdis_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && oe_n && !vpp_hi) |-> (!dq_oe && dout == '0));
  // R7
  inhibit_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && oe_n && vpp_hi) |-> !dq_oe);
  // R9
  sig_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && !vpp_hi && id_hi && !busy) |->
      (dq_oe && dout == (addr[0] ? DEV_CODE : MFG_CODE)));
  // R10
  busy_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dq_oe) |-> dout == '1);
  // R10
  erase_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (erase && !busy) |=> busy);
endmodule

bind uvprom_array uvprom_array_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MFG_CODE(MFG_CODE), .DEV_CODE(DEV_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
  .id_hi(id_hi), .addr(addr), .erase(erase), .dout(dout), .dq_oe(dq_oe),
  .busy(busy)
);

// File: tb/tb_uvprom_array.sv
module tb_uvprom_array;
  localparam int PERIOD = 10;
  localparam int DEPTH = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, vpp_hi = 1'b0, id_hi = 1'b0, erase = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic dq_oe, busy;
  int vecs = 0, errs = 0;
  bit finished = 0;

  uvprom_array dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
    .id_hi(id_hi), .addr(addr), .din(din), .erase(erase), .dout(dout),
    .dq_oe(dq_oe), .busy(busy)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [14:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    vpp_hi = 0; id_hi = 0; ce_n = 0; oe_n = 0; addr = a;
    #2; d = dout; oe = dq_oe;
    @(negedge clk); ce_n = 1; oe_n = 1;
  endtask

  task automatic vfy(input logic [14:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    vpp_hi = 1; id_hi = 0; ce_n = 1; oe_n = 0; addr = a;
    #2; d = dout; oe = dq_oe;
    @(negedge clk); oe_n = 1; vpp_hi = 0;
  endtask

  task automatic prog(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    vpp_hi = 1; oe_n = 1; ce_n = 0; addr = a; din = d;
    @(negedge clk); ce_n = 1;
    @(negedge clk); vpp_hi = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4 * DEPTH && busy; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d; logic oe;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", {7'b0, busy}, 8'h01);
    rst_n = 1;
    rd(15'd9, d, oe);
    chk("R1 busy after release", {7'b0, busy}, 8'h01);
    chk("R1 read during sweep", d, 8'hFF);
    wait_idle();
    chk("R1 busy cleared", {7'b0, busy}, 8'h00);
    rd(15'd0, d, oe);   chk("R1 blank first", d, 8'hFF);
    rd(15'd511, d, oe); chk("R1 blank last", d, 8'hFF);
  endtask

  task automatic t_hiz();
    @(negedge clk);
    vpp_hi = 0; ce_n = 1; oe_n = 0; addr = 15'd3; #2;
    chk("R5 standby oe", {7'b0, dq_oe}, 8'h00); chk("R5 standby dout", dout, 8'h00);
    oe_n = 1; #1;
    chk("R5 standby oe_n high", {7'b0, dq_oe}, 8'h00);
    ce_n = 0; oe_n = 1; #1;
    chk("R6 disable oe", {7'b0, dq_oe}, 8'h00); chk("R6 disable dout", dout, 8'h00);
    @(negedge clk); ce_n = 1;
  endtask

  task automatic t_program();
    logic [7:0] d; logic oe;
    prog(15'd5, 8'hA5);
    vfy(15'd5, d, oe);
    chk("R8 verify drives", {7'b0, oe}, 8'h01);
    chk("R8 verify data", d, 8'hA5);
    prog(15'd5, 8'hF0);
    rd(15'd5, d, oe);
    chk("R4 read drives", {7'b0, oe}, 8'h01);
    chk("R2 and merge", d, 8'hA0);
    prog(15'd5, 8'hFF);
    rd(15'd5, d, oe);
    chk("R2 no set back", d, 8'hA0);
  endtask

  task automatic t_last_sample();
    logic [7:0] d; logic oe;
    @(negedge clk);
    vpp_hi = 1; oe_n = 1; ce_n = 0; addr = 15'd20; din = 8'h0F;
    @(negedge clk); addr = 15'd21; din = 8'h3C;
    @(negedge clk); ce_n = 1;
    @(negedge clk); vpp_hi = 0;
    rd(15'd21, d, oe); chk("R3 last sample stored", d, 8'h3C);
    rd(15'd20, d, oe); chk("R3 earlier sample dropped", d, 8'hFF);
    @(negedge clk);
    vpp_hi = 1; oe_n = 1; ce_n = 0; addr = 15'd22; din = 8'h00;
    @(negedge clk); vpp_hi = 0;
    @(negedge clk); ce_n = 1;
    @(negedge clk);
    rd(15'd22, d, oe); chk("R3 no commit without supply", d, 8'hFF);
  endtask

  task automatic t_order();
    logic [7:0] d; logic oe;
    prog(15'd300, 8'h11);
    prog(15'd7, 8'h22);
    prog(15'd511, 8'h33);
    rd(15'd300, d, oe); chk("R11 random 300", d, 8'h11);
    rd(15'd7, d, oe);   chk("R11 random 7", d, 8'h22);
    rd(15'd511, d, oe); chk("R11 random 511", d, 8'h33);
    rd(15'h4005, d, oe); chk("R11 alias upper bits", d, 8'hA0);
  endtask

  task automatic t_inhibit();
    logic [7:0] d; logic oe;
    @(negedge clk);
    vpp_hi = 1; ce_n = 1; oe_n = 1; addr = 15'd7; din = 8'h00;
    #2; chk("R7 inhibit bus off", {7'b0, dq_oe}, 8'h00);
    repeat (3) @(negedge clk);
    vpp_hi = 0;
    vfy(15'd7, d, oe); chk("R7 inhibit no write", d, 8'h22);
  endtask

  task automatic t_signature();
    @(negedge clk);
    vpp_hi = 0; ce_n = 0; oe_n = 0; id_hi = 1; addr = 15'd4; #2;
    chk("R9 manufacturer", dout, 8'h97);
    addr = 15'd5; #1;
    chk("R9 device", dout, 8'h04);
    @(negedge clk); id_hi = 0; ce_n = 1; oe_n = 1;
  endtask

  task automatic t_erase();
    logic [7:0] d; logic oe;
    @(negedge clk); erase = 1;
    @(negedge clk); erase = 0;
    chk("R10 busy rises", {7'b0, busy}, 8'h01);
    rd(15'd300, d, oe); chk("R10 read during erase", d, 8'hFF);
    prog(15'd40, 8'h00);
    wait_idle();
    chk("R10 busy falls", {7'b0, busy}, 8'h00);
    rd(15'd5, d, oe);   chk("R10 erased 5", d, 8'hFF);
    rd(15'd511, d, oe); chk("R10 erased 511", d, 8'hFF);
    rd(15'd40, d, oe);  chk("R10 program while busy dropped", d, 8'hFF);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_hiz();
    t_program();
    t_last_sample();
    t_order();
    t_inhibit();
    t_signature();
    t_erase();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule